// File: doc/BRIEF.md
# Balanced-Symbol Radio Packet Encoder

This block turns a packet held in an external buffer into the synchronous serial bit stream that drives a radio transmitter. A start strobe launches a frame with these parts, in order:
- a square-wave preamble;
- an eight-bit frame marker;
- one 12-bit DC-balanced symbol per packet byte;
- a symbol for an 8-bit checksum.

For waking a remote receiver that is duty-cycling, an extended preamble can come first. It is made of groups of preamble cycles, and each group ends with a complemented marker that tells the listener to hold on.

The packet bytes are fetched through a read port with one cycle of latency. The byte count, preamble length and wake-group count are captured when the frame starts. While the frame is on air the transmit-enable output is high, and the serial line changes only at bit boundaries. When the last checksum bit has been sent, the block drops transmit-enable and pulses done.

Top module: `bsym_pkt_encoder`

## Requirements
- R1: After reset tx_en, tx_data and done are 0, and tx_data is 0 in every cycle in which tx_en is 0.
- R2: A start seen while idle raises tx_en on the next clock edge. Each transmitted bit then holds for exactly CLK_PER_BIT cycles.
- R3: The normal preamble is pre_len cycles (1 to 255), each cycle being a 0 bit followed by a 1 bit.
- R4: When wake_len is nonzero, wake_len groups come before the normal preamble. Each group is WAKE_CYCLES preamble cycles followed by the hold byte 8'b00011011, sent MSB first.
- R5: The frame marker 8'b11100100 (a seven-bit Barker code and a 0 balancing bit) is sent MSB first, straight after the preamble.
- R6: Bytes are read from addresses 0 up to byte_count-1. rd_addr selects the byte, and rd_data is taken one cycle later. Each byte b is sent MSB first as the 12-bit symbol {W(b[7:4]), W(b[3:0])}. W(n) is the n-th (counting from 0) 6-bit value in ascending order that has exactly three ones, leaving out 000111 and 111000. Every symbol therefore has six ones and no run longer than four.
- R7: After the last byte comes the symbol of the sum, modulo 256, of all byte_count bytes.
- R8: On the clock edge that ends the last checksum bit, tx_en falls and done is high for exactly one cycle.
- R9: A start during a frame is ignored. Changes to byte_count, pre_len or wake_len during a frame have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Frame start strobe (taken when idle) |
| byte_count | input | IDX_W | Packet bytes, 1 to MAX_BYTES |
| pre_len | input | 8 | Normal preamble cycles, 1 to 255 |
| wake_len | input | 8 | Wake groups, 0 for none |
| rd_addr | output | IDX_W | Packet buffer read address |
| rd_data | input | 8 | Buffer byte, valid one cycle after rd_addr |
| tx_en | output | 1 | Transmitter enable |
| tx_data | output | 1 | Serial transmit data |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The hardest case to reach is a start strobe, together with changed length inputs, arriving deep inside a frame that is already in its wake groups. A second hard case is the handover from the last data byte to the checksum symbol while the read port is already pointing past the packet. The bench uses small bit and group lengths so that long frames, including a 255-cycle preamble and a full-size packet, fit in a short run. In one frame it raises start and changes all three length inputs mid-way. A behavioural bit-queue model, built from the packet at the moment of start, is compared with the serial output on every clock.

// File: rtl/bsym_pkg.sv
package bsym_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_WAKE,
        PH_HOLD,
        PH_PRE,
        PH_SYNC,
        PH_DATA,
        PH_CSUM
    } phase_e;

    localparam logic [7:0]  SYNC_BYTE = 8'b1110_0100;
    localparam logic [7:0]  HOLD_BYTE = ~SYNC_BYTE;
    localparam logic [11:0] PRE_FIELD = 12'b01_0000000000;
endpackage

// File: rtl/bsym_nib_word.sv
module bsym_nib_word (
    input  logic [3:0] nib,
    output logic [5:0] word
);
    always_comb begin
        case (nib)
            4'h0: word = 6'b001011;
            4'h1: word = 6'b001101;
            4'h2: word = 6'b001110;
            4'h3: word = 6'b010011;
            4'h4: word = 6'b010101;
            4'h5: word = 6'b010110;
            4'h6: word = 6'b011001;
            4'h7: word = 6'b011010;
            4'h8: word = 6'b011100;
            4'h9: word = 6'b100011;
            4'hA: word = 6'b100101;
            4'hB: word = 6'b100110;
            4'hC: word = 6'b101001;
            4'hD: word = 6'b101010;
            4'hE: word = 6'b101100;
            default: word = 6'b110001;
        endcase
    end
endmodule

// File: rtl/bsym_byte_symbol.sv
module bsym_byte_symbol (
    input  logic [7:0]  byte_in,
    output logic [11:0] symbol
);
    genvar g;
    generate
        for (g = 0; g < 2; g++) begin : g_nib
            bsym_nib_word u_word (
                .nib  (byte_in[4*g+3:4*g]),
                .word (symbol[6*g+5:6*g])
            );
        end
    endgenerate
endmodule

// File: rtl/bsym_bit_timer.sv
module bsym_bit_timer #(
    parameter int CLK_PER_BIT = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int TMR_W = $clog2(CLK_PER_BIT);
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(CLK_PER_BIT - 1);

    logic [TMR_W-1:0] tmr_d, tmr_q;

    always_comb begin
        if (!run || tmr_q == TMR_LAST) tmr_d = '0;
        else                           tmr_d = tmr_q + TMR_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign tick = run && (tmr_q == TMR_LAST);
endmodule

// File: rtl/bsym_pkt_encoder.sv
module bsym_pkt_encoder #(
    parameter int CLK_PER_BIT = 256,
    parameter int MAX_BYTES   = 28,
    parameter int WAKE_CYCLES = 256,
    localparam int IDX_W = $clog2(MAX_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [IDX_W-1:0] byte_count,
    input  logic [7:0]       pre_len,
    input  logic [7:0]       wake_len,
    output logic [IDX_W-1:0] rd_addr,
    input  logic [7:0]       rd_data,
    output logic             tx_en,
    output logic             tx_data,
    output logic             done
);
    import bsym_pkg::*;

    localparam int CYC_W = ($clog2(WAKE_CYCLES) > 8) ? $clog2(WAKE_CYCLES) : 8;
    localparam logic [CYC_W-1:0] WAKE_LAST = CYC_W'(WAKE_CYCLES - 1);

    typedef struct packed {
        phase_e           ph;
        logic [11:0]      sh;
        logic [3:0]       nb;
        logic [CYC_W-1:0] cyc;
        logic [7:0]       grp;
        logic [IDX_W-1:0] idx;
        logic [IDX_W-1:0] cnt;
        logic [7:0]       sum;
        logic [7:0]       pre;
        logic [7:0]       wake;
        logic             txen;
        logic             done;
    } enc_state_t;

    enc_state_t s_q, s_d;
    logic        tick;
    logic [7:0]  sym_src;
    logic [11:0] sym;
    logic        last_byte;

    bsym_bit_timer #(.CLK_PER_BIT(CLK_PER_BIT)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (s_q.txen),
        .tick  (tick)
    );

    assign last_byte = (s_q.ph == PH_DATA) && (s_q.idx == s_q.cnt);
    assign sym_src   = last_byte ? s_q.sum : rd_data;

    bsym_byte_symbol u_sym (
        .byte_in (sym_src),
        .symbol  (sym)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (s_q.ph == PH_IDLE) begin
            if (start) begin
                s_d.txen = 1'b1;
                s_d.cnt  = byte_count;
                s_d.pre  = pre_len;
                s_d.wake = wake_len;
                s_d.idx  = '0;
                s_d.sum  = '0;
                s_d.cyc  = '0;
                s_d.grp  = '0;
                s_d.ph   = (wake_len != 8'd0) ? PH_WAKE : PH_PRE;
                s_d.sh   = PRE_FIELD;
                s_d.nb   = 4'd2;
            end
        end else if (tick) begin
            if (s_q.nb != 4'd1) begin
                s_d.sh = {s_q.sh[10:0], 1'b0};
                s_d.nb = s_q.nb - 4'd1;
            end else begin
                case (s_q.ph)
                    PH_WAKE: begin
                        if (s_q.cyc == WAKE_LAST) begin
                            s_d.ph  = PH_HOLD;
                            s_d.sh  = {HOLD_BYTE, 4'b0};
                            s_d.nb  = 4'd8;
                            s_d.cyc = '0;
                        end else begin
                            s_d.cyc = s_q.cyc + CYC_W'(1);
                            s_d.sh  = PRE_FIELD;
                            s_d.nb  = 4'd2;
                        end
                    end
                    PH_HOLD: begin
                        if ((s_q.grp + 8'd1) == s_q.wake) begin
                            s_d.ph  = PH_PRE;
                            s_d.grp = '0;
                        end else begin
                            s_d.ph  = PH_WAKE;
                            s_d.grp = s_q.grp + 8'd1;
                        end
                        s_d.sh  = PRE_FIELD;
                        s_d.nb  = 4'd2;
                        s_d.cyc = '0;
                    end
                    PH_PRE: begin
                        if ((s_q.cyc + CYC_W'(1)) == CYC_W'(s_q.pre)) begin
                            s_d.ph = PH_SYNC;
                            s_d.sh = {SYNC_BYTE, 4'b0};
                            s_d.nb = 4'd8;
                        end else begin
                            s_d.cyc = s_q.cyc + CYC_W'(1);
                            s_d.sh  = PRE_FIELD;
                            s_d.nb  = 4'd2;
                        end
                    end
                    PH_SYNC, PH_DATA: begin
                        s_d.sh = sym;
                        s_d.nb = 4'd12;
                        if (last_byte) begin
                            s_d.ph = PH_CSUM;
                        end else begin
                            s_d.ph  = PH_DATA;
                            s_d.sum = s_q.sum + rd_data;
                            s_d.idx = s_q.idx + IDX_W'(1);
                        end
                    end
                    PH_CSUM: begin
                        s_d.ph   = PH_IDLE;
                        s_d.txen = 1'b0;
                        s_d.done = 1'b1;
                        s_d.sh   = '0;
                    end
                    default: begin
                        s_d.ph   = PH_IDLE;
                        s_d.txen = 1'b0;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{ph: PH_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign rd_addr = s_q.idx;
    assign tx_en   = s_q.txen;
    assign tx_data = s_q.txen & s_q.sh[11];
    assign done    = s_q.done;
endmodule

// File: rtl/bsym_pkt_encoder_chk.sv
module bsym_pkt_encoder_chk #(
    parameter int CLK_PER_BIT = 256
) (
    input logic clk,
    input logic rst_n,
    input logic tx_en,
    input logic tx_data,
    input logic done
);
    localparam int TMR_W = $clog2(CLK_PER_BIT);
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(CLK_PER_BIT - 1);

    logic [TMR_W-1:0] bit_pos_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !tx_en)       bit_pos_q <= '0;
        else if (bit_pos_q == TMR_LAST) bit_pos_q <= '0;
        else                        bit_pos_q <= bit_pos_q + TMR_W'(1);
    end

    assert_data_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> !tx_data);

    assert_bit_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && bit_pos_q != '0) |-> $stable(tx_data));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_en) |-> done);

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !tx_en);
endmodule

bind bsym_pkt_encoder bsym_pkt_encoder_chk #(.CLK_PER_BIT(CLK_PER_BIT)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tx_en   (tx_en),
    .tx_data (tx_data),
    .done    (done)
);

// File: tb/bsym_pkt_encoder_tb.sv
module bsym_pkt_encoder_tb;
    localparam int CPB   = 8;
    localparam int MAXB  = 28;
    localparam int WAKE  = 4;
    localparam int IDX_W = $clog2(MAXB + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [IDX_W-1:0] byte_count = '0;
    logic [7:0]       pre_len = 8'd1;
    logic [7:0]       wake_len = 8'd0;
    logic [IDX_W-1:0] rd_addr;
    logic [7:0]       rd_data = 8'd0;
    logic             tx_en, tx_data, done;

    logic [7:0] mem [32];
    int checks = 0;
    int fails  = 0;
    int frames_started = 0;
    int done_seen = 0;

    always #10 clk = ~clk;

    bsym_pkt_encoder #(.CLK_PER_BIT(CPB), .MAX_BYTES(MAXB), .WAKE_CYCLES(WAKE)) u_dut (
        .clk, .rst_n, .start, .byte_count, .pre_len, .wake_len,
        .rd_addr, .rd_data, .tx_en, .tx_data, .done
    );

    always @(posedge clk) rd_data <= mem[rd_addr];

    function automatic logic [5:0] word_of(input int n);
        int k = 0;
        for (int v = 0; v < 64; v++) begin
            if ($countones(v[5:0]) == 3 && v != 7 && v != 56) begin
                if (k == n) return v[5:0];
                k++;
            end
        end
        return 6'b0;
    endfunction

    bit    q_bit[$];
    string q_tag[$];
    bit    m_busy = 0;
    bit    m_done = 0;
    int    m_tick = 0;

    task automatic push_bits(input logic [11:0] v, input int n, input string tag);
        for (int i = n - 1; i >= 0; i--) begin
            q_bit.push_back(v[i]);
            q_tag.push_back(tag);
        end
    endtask

    task automatic build_frame();
        logic [7:0] sum = 8'd0;
        for (int g = 0; g < wake_len; g++) begin
            for (int c = 0; c < WAKE; c++) push_bits(12'b01, 2, "R4");
            push_bits({4'b0, 8'b00011011}, 8, "R4");
        end
        for (int c = 0; c < pre_len; c++) push_bits(12'b01, 2, "R3");
        push_bits({4'b0, 8'b11100100}, 8, "R5");
        for (int i = 0; i < byte_count; i++) begin
            push_bits({word_of(mem[i][7:4]), word_of(mem[i][3:0])}, 12, "R6");
            sum += mem[i];
        end
        push_bits({word_of(sum[7:4]), word_of(sum[3:0])}, 12, "R7");
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_tick = 0;
            q_bit.delete(); q_tag.delete();
        end else begin
            m_done = 0;
            if (m_busy) begin
                m_tick++;
                if (m_tick == CPB) begin
                    m_tick = 0;
                    void'(q_bit.pop_front());
                    void'(q_tag.pop_front());
                    if (q_bit.size() == 0) begin
                        m_busy = 0;
                        m_done = 1;
                    end
                end
            end else if (start) begin
                build_frame();
                m_busy = 1;
                m_tick = 0;
                frames_started++;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            bit exp_d;
            string tg;
            exp_d = m_busy ? q_bit[0] : 1'b0;
            tg    = m_busy ? q_tag[0] : "R1";
            check(tx_en == m_busy, "R2", "tx_en", int'(tx_en), int'(m_busy));
            check(tx_data == exp_d, tg, "tx_data", int'(tx_data), int'(exp_d));
            check(done == m_done, "R8", "done", int'(done), int'(m_done));
            if (done) done_seen++;
        end
    end

    task automatic run_frame(input int cnt, input int pre, input int wk, input bit disturb);
        @(negedge clk);
        byte_count = IDX_W'(cnt);
        pre_len    = 8'(pre);
        wake_len   = 8'(wk);
        start      = 1'b1;
        @(negedge clk);
        start      = 1'b0;
        if (disturb) begin
            // R9: restart attempt and changed lengths mid-frame
            repeat (150) @(negedge clk);
            byte_count = IDX_W'(2);
            pre_len    = 8'd9;
            wake_len   = 8'd1;
            start      = 1'b1;
            @(negedge clk);
            start      = 1'b0;
        end
        while (!done) @(negedge clk);
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) mem[i] = 8'((i * 37 + 11) ^ (i << 3));
        mem[0] = 8'h00;
        mem[1] = 8'hFF;
        mem[2] = 8'hA5;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(tx_en == 1'b0, "R1", "reset tx_en", int'(tx_en), 0);
        check(tx_data == 1'b0, "R1", "reset tx_data", int'(tx_data), 0);
        check(done == 1'b0, "R1", "reset done", int'(done), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(tx_en == 1'b0, "R1", "idle tx_en", int'(tx_en), 0);

        run_frame(1, 1, 0, 1'b0);
        run_frame(5, 3, 0, 1'b0);
        run_frame(MAXB, 2, 0, 1'b0);
        run_frame(3, 2, 2, 1'b1);
        mem[0] = 8'h7E;
        run_frame(4, 255, 0, 1'b0);
        run_frame(2, 1, 1, 1'b0);

        // R9: the mid-frame start must not have launched an extra frame
        check(done_seen == frames_started, "R9", "frames done", done_seen, frames_started);
        check(frames_started == 6, "R9", "frames accepted", frames_started, 6);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule